// File: doc/BRIEF.md
# Memory Barrier Issue Controller

This block sits beside an in-order issue stage and handles memory barrier instructions. Each barrier carries a 7-bit mask. The controller sorts the mask into one of three classes. The first class retires at once. The second holds back younger loads until older stores are globally visible. The third stops every younger instruction until all older work has drained. The issue stage then drops the stalled operations until the matching stall line falls. A single-cycle pulse marks that the barrier has retired, or that it was squashed because an older operation raised an exception.

The memory model is strict. Stores are performed in program order and after every older load, and loads are performed after older loads. Because of this, three of the four ordering bits need no action. The only ordering bit that needs a wait is the store-then-load bit. The three completion bits all map to one full drain. The block holds one barrier at a time and refuses a second barrier through a ready line while the first is outstanding. It assumes that no younger instruction issues in the same cycle as the barrier it follows, so stalls are driven from the registered barrier slot.

Top module: `membar_issue_ctrl`

## Requirements
- R1: After reset, and in any cycle following a cycle with reset low, the slot is empty: `bar_ready` is 1, all three stall outputs are 0 and neither `bar_retire` nor `bar_kill` is high while `bar_valid` is 0.
- R2: Mask bits 3..0 form the ordering field (bit 3 store→store, bit 2 load→store, bit 1 store→load, bit 0 load→load). Mask bits 6..4 form the completion field (bit 6 full sync, bit 5 memory issue, bit 4 lookaside).
- R3: A barrier with completion field zero and bit 1 clear retires in its accept cycle (`bar_retire` high while `bar_valid` and `bar_ready` are high). It never raises a stall and leaves `bar_ready` high in the next cycle, whatever bits 3, 2 and 0 hold.
- R4: A barrier with completion field zero and bit 1 set raises `stall_ld` only, from the cycle after acceptance. It keeps that stall until a cycle in which `old_st_cnt` is 0 and `st_visible` is 1. In that cycle `stall_ld` is 0 and `bar_retire` pulses.
- R5: A barrier with any of bits 6, 5 or 4 set raises `stall_ld`, `stall_st` and `stall_all` together from the cycle after acceptance. Each of the three bits alone behaves identically.
- R6: A full barrier is released in the first cycle in which all three outstanding counts are 0 and `exc_pending` is 0. In that cycle all stalls are 0 and `bar_retire` pulses.
- R7: If `exc_pending` is 1 in a cycle while a full barrier is held, `bar_kill` pulses, `bar_retire` stays 0, all stalls are 0 in that cycle and the slot is freed.
- R8: While a barrier is held, `bar_ready` is 0. A `bar_valid` request in such a cycle has no effect: it causes no retire and does not replace the held barrier.
- R9: When the completion field is nonzero and bit 1 is also set, release additionally requires `st_visible` to be 1.
- R10: `bar_retire` and `bar_kill` are never high in the same cycle. The first cycle after a release shows `bar_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_valid | input | 1 | Barrier instruction presented this cycle |
| bar_mask | input | 7 | Barrier mask (ordering field 3..0, completion field 6..4) |
| bar_ready | output | 1 | Slot free; a presented barrier is accepted |
| old_ld_cnt | input | CNT_W | Outstanding older loads |
| old_st_cnt | input | CNT_W | Outstanding older stores |
| old_op_cnt | input | CNT_W | Outstanding older non-memory operations |
| st_visible | input | 1 | All older stores are globally visible |
| exc_pending | input | 1 | An older operation has raised an exception |
| stall_ld | output | 1 | Hold younger loads |
| stall_st | output | 1 | Hold younger stores |
| stall_all | output | 1 | Hold every younger instruction |
| bar_retire | output | 1 | One-cycle pulse: barrier completed |
| bar_kill | output | 1 | One-cycle pulse: barrier squashed by exception |

## Verification
The bench walks every no-op ordering bit and combination of them. A design that stalled on any of these would show a stall or a late retire pulse. It holds store→load barriers with the store count at zero but visibility low, and with visibility high but stores still counted, so that a half-checked release condition retires early. Each completion bit is tried on its own to catch a lighter bit that was not promoted to a full drain. The bench also combines a completion bit with bit 1 to expose a sync release that ignores store visibility. It raises an exception under a full barrier to catch a retire in place of a squash, and presents barriers while the slot is busy to catch an overwrite or an immediate retire. A mid-barrier reset confirms that the slot and the stalls clear.

// File: rtl/membar_pkg.sv
// Package: shared encodings for the barrier issue controller.
// Assumes a 7-bit barrier mask; bit positions are architectural.
package membar_pkg;

    localparam int MASK_W = 7;

    // Ordering field bit positions
    localparam int B_LDLD = 0;
    localparam int B_STLD = 1;
    localparam int B_LDST = 2;
    localparam int B_STST = 3;
    // Completion field bit positions
    localparam int B_LOOK = 4;
    localparam int B_MISS = 5;
    localparam int B_SYNC = 6;

    // Number of outstanding-work sources and their index in the count vector
    localparam int N_SRC  = 3;
    localparam int SRC_LD = 0;
    localparam int SRC_ST = 1;
    localparam int SRC_OP = 2;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,   // retires on accept
        K_STLD = 2'd1,   // wait for older stores visible, hold loads
        K_FULL = 2'd2    // full drain, hold everything
    } bar_kind_e;

    typedef struct packed {
        bar_kind_e kind;
        logic      need_vis;   // store-visible flag also required
    } bar_req_t;

endpackage

// File: rtl/membar_decode.sv
// Module: membar_decode
// Classifies a barrier mask into one of three actions. Assumes a strict
// in-order memory model, so only the store-to-load ordering bit matters in
// the ordering field, and every completion bit maps to a full drain.
module membar_decode
    import membar_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    output bar_req_t          req
);

    logic cmp_any;
    logic unused_order_bits;

    assign cmp_any           = |mask[B_SYNC:B_LOOK];
    // These ordering bits are satisfied by the in-order pipeline itself.
    assign unused_order_bits = ^{mask[B_STST], mask[B_LDST], mask[B_LDLD]};

    // Purpose: pick the barrier class and whether store visibility is needed.
    always_comb begin
        req.need_vis = mask[B_STLD];
        if (cmp_any) begin
            req.kind = K_FULL;
        end else if (mask[B_STLD]) begin
            req.kind = K_STLD;
        end else begin
            req.kind = K_NONE;
        end
    end

endmodule

// File: rtl/membar_cond.sv
// Module: membar_cond
// Evaluates the release conditions from the outstanding-work counts.
// Assumes counts are exact and zero means nothing older is in flight.
module membar_cond
    import membar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [N_SRC-1:0][CNT_W-1:0] cnt,
    input  logic                        st_visible,
    input  logic                        exc_pending,
    input  logic                        need_vis,
    output logic                        stld_met,
    output logic                        sync_met
);

    logic [N_SRC-1:0] src_idle;

    // One zero detector per outstanding-work source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_idle
        assign src_idle[i] = (cnt[i] == '0);
    end

    // Purpose: combine the per-source idle flags into the two release terms.
    always_comb begin
        stld_met = src_idle[SRC_ST] && st_visible;
        sync_met = (&src_idle) && !exc_pending && (!need_vis || st_visible);
    end

endmodule

// File: rtl/membar_slot.sv
// Module: membar_slot
// Holds the single outstanding barrier and drives the stall lines.
// Assumes load is only asserted while the slot is empty.
module membar_slot
    import membar_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  bar_req_t load_req,
    input  logic     stld_met,
    input  logic     sync_met,
    input  logic     exc_pending,
    output logic     busy,
    output logic     held_vis,
    output logic     rel_ok,
    output logic     rel_kill,
    output logic     stall_ld,
    output logic     stall_st,
    output logic     stall_all
);

    bar_kind_e held_kind;
    logic      release_now;
    logic      full_hold;

    // Purpose: decide this cycle's release or squash of the held barrier.
    always_comb begin
        rel_kill    = busy && (held_kind == K_FULL) && exc_pending;
        rel_ok      = busy && ((held_kind == K_FULL) ? sync_met : stld_met);
        release_now = rel_ok || rel_kill;
    end

    // Purpose: stall lines fall in the same cycle the barrier releases.
    always_comb begin
        full_hold = busy && !release_now && (held_kind == K_FULL);
        stall_ld  = busy && !release_now;
        stall_st  = full_hold;
        stall_all = full_hold;
    end

    // Purpose: fill and empty the single barrier slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            held_kind <= K_NONE;
            held_vis  <= 1'b0;
        end else if (busy && release_now) begin
            busy      <= 1'b0;
            held_kind <= K_NONE;
            held_vis  <= 1'b0;
        end else if (load) begin
            busy      <= 1'b1;
            held_kind <= load_req.kind;
            held_vis  <= load_req.need_vis;
        end
    end

    // A full barrier never completes while an exception is flagged.
    p_sync_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ok && held_kind == K_FULL) |-> !exc_pending);

    // Retire and squash are exclusive.
    p_one_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_ok && rel_kill));

    // A released slot is empty on the following cycle.
    p_slot_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_ok || rel_kill) |=> !busy);

endmodule

// File: rtl/membar_issue_ctrl.sv
// Module: membar_issue_ctrl (top)
// Accepts one barrier at a time, classifies it, and stalls younger issue
// until its release condition holds. Assumes the issue stage does not issue
// a younger instruction in the same cycle the barrier is accepted.
module membar_issue_ctrl
    import membar_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bar_valid,
    input  logic [MASK_W-1:0] bar_mask,
    output logic              bar_ready,
    input  logic [CNT_W-1:0]  old_ld_cnt,
    input  logic [CNT_W-1:0]  old_st_cnt,
    input  logic [CNT_W-1:0]  old_op_cnt,
    input  logic              st_visible,
    input  logic              exc_pending,
    output logic              stall_ld,
    output logic              stall_st,
    output logic              stall_all,
    output logic              bar_retire,
    output logic              bar_kill
);

    bar_req_t                    dec_req;
    logic [N_SRC-1:0][CNT_W-1:0] cnt_vec;
    logic                        stld_met;
    logic                        sync_met;
    logic                        busy;
    logic                        held_vis;
    logic                        rel_ok;
    logic                        accept;
    logic                        load;

    assign cnt_vec[SRC_LD] = old_ld_cnt;
    assign cnt_vec[SRC_ST] = old_st_cnt;
    assign cnt_vec[SRC_OP] = old_op_cnt;

    membar_decode u_dec (
        .mask (bar_mask),
        .req  (dec_req)
    );

    membar_cond #(.CNT_W(CNT_W)) u_cond (
        .cnt         (cnt_vec),
        .st_visible  (st_visible),
        .exc_pending (exc_pending),
        .need_vis    (held_vis),
        .stld_met    (stld_met),
        .sync_met    (sync_met)
    );

    membar_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_req    (dec_req),
        .stld_met    (stld_met),
        .sync_met    (sync_met),
        .exc_pending (exc_pending),
        .busy        (busy),
        .held_vis    (held_vis),
        .rel_ok      (rel_ok),
        .rel_kill    (bar_kill),
        .stall_ld    (stall_ld),
        .stall_st    (stall_st),
        .stall_all   (stall_all)
    );

    // Purpose: handshake and the slot-fill request for waiting barriers.
    always_comb begin
        bar_ready = !busy;
        accept    = bar_valid && bar_ready;
        load      = accept && (dec_req.kind != K_NONE);
    end

    // Purpose: retire from the slot, or at once for a no-op barrier.
    always_comb begin
        bar_retire = rel_ok || (accept && (dec_req.kind == K_NONE));
    end

    // A waiting barrier closes the slot on the next cycle.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && bar_ready && (bar_mask[B_STLD] || |bar_mask[B_SYNC:B_LOOK]))
        |=> !bar_ready);

    // A full barrier stalls loads and stores along with everything else.
    p_full_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_all |-> (stall_ld && stall_st));

    // A squash drops every stall in the same cycle.
    p_kill_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bar_kill |-> !(stall_ld || stall_st || stall_all || bar_retire));

    // A store-to-load hold persists only while its condition is unmet.
    p_stld_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_ld && !stall_all) |-> !((old_st_cnt == '0) && st_visible));

    // A retire while the slot is busy needs the older stores drained.
    p_retire_drained_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_retire && !bar_ready) |-> (old_st_cnt == '0));

endmodule

// File: tb/sim_membar_issue_ctrl.sv
module sim_membar_issue_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bar_valid = 1'b0;
    logic [6:0]       bar_mask = '0;
    logic             bar_ready;
    logic [CNT_W-1:0] old_ld_cnt = '0;
    logic [CNT_W-1:0] old_st_cnt = '0;
    logic [CNT_W-1:0] old_op_cnt = '0;
    logic             st_visible = 1'b1;
    logic             exc_pending = 1'b0;
    logic             stall_ld, stall_st, stall_all, bar_retire, bar_kill;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference state: 0 empty, 1 store-to-load wait, 2 full drain
    int  m_kind = 0;
    bit  m_vis  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    membar_issue_ctrl #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_mask(bar_mask),
        .bar_ready(bar_ready), .old_ld_cnt(old_ld_cnt), .old_st_cnt(old_st_cnt),
        .old_op_cnt(old_op_cnt), .st_visible(st_visible), .exc_pending(exc_pending),
        .stall_ld(stall_ld), .stall_st(stall_st), .stall_all(stall_all),
        .bar_retire(bar_retire), .bar_kill(bar_kill)
    );

    // One clock: drive at negedge, compare against the model, advance the model.
    task automatic step(input bit v, input logic [6:0] m, input int ld, input int st,
                        input int op, input bit vis, input bit exc, input bit rst,
                        input string req);
        bit e_ready, e_sld, e_sst, e_sall, e_ret, e_kill, done, kill, acc, comp;
        @(negedge clk);
        bar_valid = v; bar_mask = m;
        old_ld_cnt = CNT_W'(ld); old_st_cnt = CNT_W'(st); old_op_cnt = CNT_W'(op);
        st_visible = vis; exc_pending = exc; rst_n = !rst;
        #1;
        comp = |m[6:4];
        done = 1'b0; kill = 1'b0;
        if (m_kind == 1) done = (st == 0) && vis;
        if (m_kind == 2) begin
            kill = exc;
            done = !exc && ld == 0 && st == 0 && op == 0 && (!m_vis || vis);
        end
        acc     = v && (m_kind == 0);
        e_ready = (m_kind == 0);
        e_sld   = (m_kind != 0) && !done && !kill;
        e_sst   = (m_kind == 2) && !done && !kill;
        e_sall  = e_sst;
        e_kill  = kill;
        e_ret   = done || (acc && !comp && !m[1]);
        n_run++;
        if ({bar_ready, stall_ld, stall_st, stall_all, bar_retire, bar_kill} !==
            {e_ready, e_sld, e_sst, e_sall, e_ret, e_kill}) begin
            n_fail++;
            $display("FAIL %s t=%0t rdy/sld/sst/sall/ret/kill got %b%b%b%b%b%b exp %b%b%b%b%b%b",
                     req, $time, bar_ready, stall_ld, stall_st, stall_all, bar_retire,
                     bar_kill, e_ready, e_sld, e_sst, e_sall, e_ret, e_kill);
        end
        if (rst) begin
            m_kind = 0; m_vis = 1'b0;
        end else if (done || kill) begin
            m_kind = 0; m_vis = 1'b0;
        end else if (acc && (comp || m[1])) begin
            m_kind = comp ? 2 : 1; m_vis = m[1];
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 7'h00, 0, 0, 0, 1, 0, 0, req);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        step(0, 7'h00, 0, 0, 0, 1, 0, 1, "R1");
        step(0, 7'h00, 0, 0, 0, 1, 0, 1, "R1");
        idle(2, "R1");

        // R3 / R2: ordering-only masks without bit 1 retire on accept
        foreach (m_list_dummy[i]) ;
        for (int m = 0; m < 16; m++) begin
            if (m[1] == 1'b0) begin
                step(1, 7'(m), 3, 5, 2, 0, 0, 0, "R3");
                step(0, 7'h00, 3, 5, 2, 0, 0, 0, "R3");
            end
        end

        // R4: store-to-load barrier, partial conditions then release
        step(1, 7'h02, 0, 4, 0, 0, 0, 0, "R4");
        step(0, 7'h00, 2, 4, 1, 1, 0, 0, "R4");
        step(0, 7'h00, 2, 0, 1, 0, 0, 0, "R4");
        step(0, 7'h00, 2, 1, 1, 1, 1, 0, "R4");
        step(0, 7'h00, 2, 0, 1, 1, 0, 0, "R4");
        idle(1, "R10");
        // R4 with all ordering bits set
        step(1, 7'h0F, 0, 0, 0, 1, 0, 0, "R4");
        step(0, 7'h00, 0, 0, 0, 1, 0, 0, "R4");

        // R5 / R6: each completion bit alone drains fully
        for (int b = 4; b < 7; b++) begin
            step(1, 7'(1 << b), 1, 1, 1, 1, 0, 0, "R5");
            step(0, 7'h00, 1, 1, 1, 1, 0, 0, "R5");
            step(0, 7'h00, 0, 0, 1, 1, 0, 0, "R6");
            step(0, 7'h00, 1, 0, 0, 1, 0, 0, "R6");
            step(0, 7'h00, 0, 0, 0, 0, 0, 0, "R6");
            idle(1, "R10");
        end

        // R9: completion plus store-to-load needs visibility
        step(1, 7'h42, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 7'h00, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 7'h00, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 7'h00, 0, 0, 0, 1, 0, 0, "R9");

        // R7: exception squashes a full barrier
        step(1, 7'h20, 2, 0, 0, 1, 0, 0, "R7");
        step(0, 7'h00, 2, 0, 0, 1, 0, 0, "R7");
        step(0, 7'h00, 2, 0, 0, 1, 1, 0, "R7");
        step(0, 7'h00, 2, 0, 0, 1, 0, 0, "R7");

        // R8: requests while busy are ignored
        step(1, 7'h50, 0, 3, 0, 1, 0, 0, "R8");
        step(1, 7'h00, 0, 3, 0, 1, 0, 0, "R8");
        step(1, 7'h02, 0, 3, 0, 1, 0, 0, "R8");
        step(1, 7'h00, 0, 0, 0, 1, 0, 0, "R8");
        step(1, 7'h00, 0, 0, 0, 1, 0, 0, "R10");

        // R1: reset during a held barrier clears it
        step(1, 7'h40, 1, 1, 1, 1, 0, 0, "R1");
        step(0, 7'h00, 1, 1, 1, 1, 0, 1, "R1");
        step(0, 7'h00, 1, 1, 1, 1, 0, 0, "R1");
        idle(2, "R1");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    int m_list_dummy[0:0];

endmodule